// File: doc/BRIEF.md
# GPIO Port with Level Alarms

This block is a general-purpose I/O port whose bits each have their own direction. A small command interface drives it. On each cycle a caller may present an 8-bit opcode and a bit-mask argument. The block updates its state and registers a result word, which is visible from the next cycle on.

The block holds an output shadow register. Masked commands set bits in it or clear bits in it atomically. Other masked commands turn port bits into inputs or outputs. The caller can read back the synchronized input pins, the output shadow and the direction mask.

Each bit can also be armed to raise an alarm. A high alarm fires while that pin is high, and a low alarm fires while that pin is low. The alarm-pending output is level-sensitive. It stays asserted while any armed condition holds, and it drops when the condition goes away or the bit is disarmed.

Top module: `gpio_alarm_port`

## Requirements
- R1: After reset, pin_oe and pin_out are all zero, no alarm is armed, alarm_pend is 0 and result is 0.
- R2: Opcode 0x02 sets to 1 each shadow bit whose argument bit is 1 and keeps every other bit. The result is the updated shadow. pin_out always equals the shadow, whatever the direction of each bit.
- R3: Opcode 0x03 clears to 0 each shadow bit whose argument bit is 1 and keeps every other bit. The result is the updated shadow.
- R4: Opcode 0x09 makes each bit whose argument bit is 1 an input, writing 0 into pin_oe (where 0 means input and 1 means output). Other bits keep their direction. The result is the mask of current inputs, which is the inverse of the new pin_oe.
- R5: Opcode 0x0A makes each bit whose argument bit is 1 an output, writing 1 into pin_oe. Other bits keep their direction. The result is the mask of current outputs, which is the new pin_oe.
- R6: Opcode 0x04 arms a high alarm on the marked bits, and the result is the updated high-armed mask. Opcode 0x05 arms a low alarm on the marked bits, and the result is the updated low-armed mask. alarm_pend is 1 exactly when some high-armed bit has a synchronized pin of 1 or some low-armed bit has a synchronized pin of 0.
- R7: Opcode 0x06 removes both the high and the low arming from the marked bits. The result is the OR of the high-armed and low-armed masks that remain. alarm_pend is level-sensitive: it falls once the armed condition no longer holds.
- R8: Each input pin passes through a synchronizer with SYNC_STAGES flops, 2 by default. A change on a pin reaches alarm_pend and the read-inputs result 2 clock edges later. Opcode 0x10 returns the synchronized pins.
- R9: Opcode 0x11 returns the output shadow without changing it.
- R10: Any other opcode changes no state and returns a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_arg | input | WIDTH | Bit-mask argument |
| pin_in | input | WIDTH | Asynchronous input pins |
| pin_out | output | WIDTH | Output shadow driven to the pads |
| pin_oe | output | WIDTH | Per-bit output enable (1 = output) |
| result | output | WIDTH | Registered result of the last command |
| alarm_pend | output | 1 | Level alarm pending |

## Verification
On every cycle, the assertions check the cross-cycle effect of each masked command:
- a set or clear touches only the marked shadow bits;
- a direction command touches only the marked bits;
- a clear-alarm command leaves its marked bits disarmed;
- the direction mask holds steady on any other command;
- an unknown opcode changes nothing and returns 0.

Only the bench scenarios can show the result words, the two-edge delay through the input synchronizer, and the alarm falling when a pin returns to its idle level. The bench covers these with directed cases and a long seeded random mix of commands and pin changes.

// File: rtl/gpio_alarm_pkg.sv
package gpio_alarm_pkg;
   localparam int OP_W = 8;

   localparam logic [OP_W-1:0] OP_SET_BITS  = 8'h02;
   localparam logic [OP_W-1:0] OP_CLR_BITS  = 8'h03;
   localparam logic [OP_W-1:0] OP_ARM_HIGH  = 8'h04;
   localparam logic [OP_W-1:0] OP_ARM_LOW   = 8'h05;
   localparam logic [OP_W-1:0] OP_DISARM    = 8'h06;
   localparam logic [OP_W-1:0] OP_MAKE_IN   = 8'h09;
   localparam logic [OP_W-1:0] OP_MAKE_OUT  = 8'h0A;
   localparam logic [OP_W-1:0] OP_RD_PINS   = 8'h10;
   localparam logic [OP_W-1:0] OP_RD_SHADOW = 8'h11;

   function automatic logic op_is_known(input logic [OP_W-1:0] op);
      return (op == OP_SET_BITS) || (op == OP_CLR_BITS) || (op == OP_ARM_HIGH) ||
             (op == OP_ARM_LOW) || (op == OP_DISARM) || (op == OP_MAKE_IN) ||
             (op == OP_MAKE_OUT) || (op == OP_RD_PINS) || (op == OP_RD_SHADOW);
   endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_async,
   output logic [WIDTH-1:0] pin_sync
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [WIDTH-1:0] stage_q [SYNC_STAGES];

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("gpio_in_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= pin_async;
         for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign pin_sync = stage_q[LAST];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_alarm_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [OP_W-1:0]  cmd_op,
   input  logic [WIDTH-1:0] cmd_arg,
   output logic [WIDTH-1:0] shadow_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] shadow_nxt,
   output logic [WIDTH-1:0] dir_nxt
);
   always_comb begin
      shadow_nxt = shadow_q;
      dir_nxt    = dir_q;
      if (cmd_valid) begin
         case (cmd_op)
            OP_SET_BITS: shadow_nxt = shadow_q | cmd_arg;
            OP_CLR_BITS: shadow_nxt = shadow_q & ~cmd_arg;
            OP_MAKE_IN:  dir_nxt    = dir_q & ~cmd_arg;
            OP_MAKE_OUT: dir_nxt    = dir_q | cmd_arg;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         dir_q    <= '0;
      end else begin
         shadow_q <= shadow_nxt;
         dir_q    <= dir_nxt;
      end
   end

   AST_SET_ONLY_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_SET_BITS) |=> (shadow_q == ($past(shadow_q) | $past(cmd_arg)))); // R2
   AST_CLR_ONLY_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_CLR_BITS) |=> (shadow_q == ($past(shadow_q) & ~$past(cmd_arg)))); // R3
   AST_DIR_IN_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_MAKE_IN) |=> ((dir_q & $past(cmd_arg)) == '0 &&
                                               (dir_q & ~$past(cmd_arg)) == ($past(dir_q) & ~$past(cmd_arg)))); // R4
   AST_DIR_OUT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_MAKE_OUT) |=> ((dir_q & $past(cmd_arg)) == $past(cmd_arg) &&
                                                (dir_q & ~$past(cmd_arg)) == ($past(dir_q) & ~$past(cmd_arg)))); // R5
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && (cmd_op == OP_MAKE_IN || cmd_op == OP_MAKE_OUT)) |=> $stable(dir_q)); // R10
endmodule

// File: rtl/gpio_alarm_unit.sv
module gpio_alarm_unit
   import gpio_alarm_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [OP_W-1:0]  cmd_op,
   input  logic [WIDTH-1:0] cmd_arg,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] arm_hi_nxt,
   output logic [WIDTH-1:0] arm_lo_nxt,
   output logic             alarm_pend
);
   logic [WIDTH-1:0] arm_hi_q;
   logic [WIDTH-1:0] arm_lo_q;
   logic [WIDTH-1:0] bit_hit;

   always_comb begin
      arm_hi_nxt = arm_hi_q;
      arm_lo_nxt = arm_lo_q;
      if (cmd_valid) begin
         case (cmd_op)
            OP_ARM_HIGH: arm_hi_nxt = arm_hi_q | cmd_arg;
            OP_ARM_LOW:  arm_lo_nxt = arm_lo_q | cmd_arg;
            OP_DISARM: begin
               arm_hi_nxt = arm_hi_q & ~cmd_arg;
               arm_lo_nxt = arm_lo_q & ~cmd_arg;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_hi_q <= '0;
         arm_lo_q <= '0;
      end else begin
         arm_hi_q <= arm_hi_nxt;
         arm_lo_q <= arm_lo_nxt;
      end
   end

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         assign bit_hit[b] = (arm_hi_q[b] & pin_sync[b]) | (arm_lo_q[b] & ~pin_sync[b]);
      end
   endgenerate

   assign alarm_pend = |bit_hit;

   AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_DISARM) |=> (((arm_hi_q | arm_lo_q) & $past(cmd_arg)) == '0)); // R7
   AST_IDLE_NO_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_hi_q == '0 && arm_lo_q == '0) |-> !alarm_pend); // R6
   AST_ARM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_ARM_HIGH) |=> ((arm_hi_q & $past(cmd_arg)) == $past(cmd_arg) && $stable(arm_lo_q))); // R6
endmodule

// File: rtl/gpio_alarm_port.sv
module gpio_alarm_port
   import gpio_alarm_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_op,
   input  logic [WIDTH-1:0] cmd_arg,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] result,
   output logic             alarm_pend
);
   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] shadow_q, dir_q, shadow_nxt, dir_nxt;
   logic [WIDTH-1:0] arm_hi_nxt, arm_lo_nxt;
   logic [WIDTH-1:0] result_nxt;
   logic [WIDTH-1:0] result_q;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_alarm_port: WIDTH must be positive");
      end
   endgenerate

   gpio_in_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(pin_sync));

   gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
      .shadow_q(shadow_q), .dir_q(dir_q), .shadow_nxt(shadow_nxt), .dir_nxt(dir_nxt));

   gpio_alarm_unit #(.WIDTH(WIDTH)) u_alarm (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
      .pin_sync(pin_sync), .arm_hi_nxt(arm_hi_nxt), .arm_lo_nxt(arm_lo_nxt),
      .alarm_pend(alarm_pend));

   always_comb begin
      case (cmd_op)
         OP_SET_BITS, OP_CLR_BITS: result_nxt = shadow_nxt;
         OP_ARM_HIGH:              result_nxt = arm_hi_nxt;
         OP_ARM_LOW:               result_nxt = arm_lo_nxt;
         OP_DISARM:                result_nxt = arm_hi_nxt | arm_lo_nxt;
         OP_MAKE_IN:               result_nxt = ~dir_nxt;
         OP_MAKE_OUT:              result_nxt = dir_nxt;
         OP_RD_PINS:               result_nxt = pin_sync;
         OP_RD_SHADOW:             result_nxt = shadow_q;
         default:                  result_nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         result_q <= '0;
      else if (cmd_valid) result_q <= result_nxt;
   end

   assign result  = result_q;
   assign pin_out = shadow_q;
   assign pin_oe  = dir_q;

   AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !op_is_known(cmd_op)) |=> ($stable(pin_out) && $stable(pin_oe) && result == '0)); // R10
   AST_READ_SHADOW_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_RD_SHADOW) |=> ($stable(pin_out) && result == pin_out)); // R9
endmodule

// File: tb/tb_gpio_alarm_port.sv
`timescale 1ns/1ps
module tb_gpio_alarm_port;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [7:0]   cmd_op = '0;
   logic [W-1:0] cmd_arg = '0;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] pin_out, pin_oe, result;
   logic         alarm_pend;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   logic [W-1:0] m_out, m_dir, m_hi, m_lo;

   always #2.5 clk = ~clk;

   gpio_alarm_port #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .result(result),
      .alarm_pend(alarm_pend));

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic model_alarm(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                        input logic [W-1:0] pins);
      return |((hi & pins) | (lo & ~pins));
   endfunction

   // Updates the model and returns the expected result word.
   function automatic logic [W-1:0] model_cmd(input logic [7:0] op, input logic [W-1:0] arg,
                                              input logic [W-1:0] pins);
      logic [W-1:0] r;
      case (op)
         8'h02: begin m_out = m_out | arg;  r = m_out; end
         8'h03: begin m_out = m_out & ~arg; r = m_out; end
         8'h04: begin m_hi = m_hi | arg;    r = m_hi; end
         8'h05: begin m_lo = m_lo | arg;    r = m_lo; end
         8'h06: begin m_hi = m_hi & ~arg; m_lo = m_lo & ~arg; r = m_hi | m_lo; end
         8'h09: begin m_dir = m_dir & ~arg; r = ~m_dir; end
         8'h0A: begin m_dir = m_dir | arg;  r = m_dir; end
         8'h10: r = pins;
         8'h11: r = m_out;
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic issue(input logic [7:0] op, input logic [W-1:0] arg);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic cmd_check(input string tag, input logic [7:0] op, input logic [W-1:0] arg);
      logic [W-1:0] exp;
      exp = model_cmd(op, arg, pin_in);
      issue(op, arg);
      check({tag, " result"}, result, exp);
      check({tag, " pin_out"}, pin_out, m_out);
      check({tag, " pin_oe"}, pin_oe, m_dir);
      check({tag, " alarm"}, {{(W-1){1'b0}}, alarm_pend}, {{(W-1){1'b0}}, model_alarm(m_hi, m_lo, pin_in)});
   endtask

   task automatic settle_pins(input logic [W-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] ops [10];
      ops = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h09, 8'h0A, 8'h10, 8'h11, 8'h07};
      void'($urandom(32'd20240611));
      m_out = '0; m_dir = '0; m_hi = '0; m_lo = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pin_oe", pin_oe, '0);
      check("R1 pin_out", pin_out, '0);
      check("R1 result", result, '0);
      check("R1 alarm", {31'b0, alarm_pend}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      cmd_check("R2 set", 8'h02, 32'hF0F0_00FF);
      cmd_check("R2 set again", 8'h02, 32'h0000_0F00);
      cmd_check("R3 clear", 8'h03, 32'h00F0_000F);
      cmd_check("R5 make out", 8'h0A, 32'hFFFF_0000);
      cmd_check("R4 make in", 8'h09, 32'h0F00_0000);
      cmd_check("R9 read shadow", 8'h11, 32'hDEAD_BEEF);
      cmd_check("R10 unknown", 8'h07, 32'hFFFF_FFFF);
      cmd_check("R10 unknown hi", 8'hFF, 32'hFFFF_FFFF);

      // R8 synchronizer latency
      @(negedge clk);
      pin_in = 32'h0000_0001;
      cmd_check("R6 arm high", 8'h04, 32'h0000_0001);
      // pin changed one negedge before the arm command edge: 1 edge only so far
      // then command edge = 2nd edge, so alarm seen now
      @(negedge clk);
      pin_in = 32'h0;
      @(negedge clk);
      check("R8 alarm held after 1 edge", {31'b0, alarm_pend}, 32'h1);
      @(negedge clk);
      check("R7 alarm falls with pin", {31'b0, alarm_pend}, 32'h0);
      cmd_check("R8 read pins", 8'h10, 32'h0);
      settle_pins(32'h8000_0000);
      cmd_check("R8 read pins high", 8'h10, 32'h0);
      cmd_check("R6 arm low", 8'h05, 32'h0000_0010);
      cmd_check("R7 disarm", 8'h06, 32'h0000_0010);
      cmd_check("R7 disarm rest", 8'h06, 32'h0000_0001);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 4) == 0) settle_pins($urandom);
         cmd_check("Rmix R2 R3 R4 R5 R6 R7 R8 R9 R10", ops[$urandom % 10], $urandom);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule